// File: doc/BRIEF.md
# Compare-Match Timer with Watchdog Reset

This block is a free-running microsecond timer with a set of compare channels. It is reached over a small register bus with single-cycle writes and reads that return one cycle later. A prescaler divides the system clock down to a 1 MHz tick. On each tick a 32-bit counter steps by one. When the counter steps onto a channel's compare value, that channel's sticky status bit is set. Any status bit whose enable is also set drives the interrupt line.

One channel also serves as the watchdog comparator. There is no separate down-counter. Software arms the watchdog by setting the watchdog enable and that channel's interrupt enable. A match on that channel then produces a fixed-length reset pulse. Software keeps the system alive by moving the compare value forward. To do this, it first takes a snapshot of the counter through the latch trigger, then writes snapshot plus timeout into the watchdog compare register. The compare value may wrap past 2^32, so the time left is always compare minus counter, modulo 2^32.

Register byte offsets, each a 32-bit word:

| Offset | Register |
|--------|----------|
| 0x00 | live counter, read-only |
| 0x08 + 4·n | compare value of channel n |
| 0x24 | interrupt enable, bit n for channel n |
| 0x28 | watchdog enable, bit 0 |
| 0x2C | status, write 1 to clear |
| 0x30 | latch trigger |
| 0x34 | snapshot |

Top module: `tcw_timer_wdog`

## Requirements
- R1: The counter at offset 0x00 steps by exactly one every CLK_HZ/TICK_HZ system clocks. Writes to offset 0x00 do not change it.
- R2: After reset, the counter, interrupt enable, watchdog enable, status and snapshot are zero. Every compare register reads 0xFFFFFFFF. `irq_o` and `wdog_rst_o` are low.
- R3: The compare register of channel n, at offset 0x08 + 4·n, stores a full 32-bit write and reads it back.
- R4: A write to 0x30 with bit 0 set copies the live counter into the snapshot register at 0x34. The snapshot holds its value until the next such write. A write to 0x30 with bit 0 clear has no effect.
- R5: Status bit n is set only when the counter steps onto channel n's compare value exactly. Once set, it stays set.
- R6: Status reads at 0x2C. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: `irq_o` is high one clock after any channel has both its status bit and its enable bit set. It stays low while every set status bit is masked.
- R8: A match on channel 5 starts a reset pulse only when watchdog enable bit 0 is 1 and interrupt enable bit 5 is 1. With bit 5 clear, no pulse occurs.
- R9: The reset pulse lasts exactly RST_LEN (16) clocks. Channel 5 matches that occur while the pulse is high do not extend it or start a second pulse.
- R10: While watchdog enable bit 0 is 0, no reset pulse is started, whatever the compare value.
- R11: `bus_rvalid` rises one clock after each read strobe. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| irq_o | output | 1 | Registered interrupt: any enabled status bit set |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions check the following on every cycle:
- The counter stays still between ticks and steps by one on a tick.
- The snapshot changes only on a trigger, and then takes the prior counter value.
- A match always leaves its status bit set.
- An enabled pending status always raises the interrupt.
- A reset pulse never starts without both enables, is never longer than 16 cycles, and always ends at exactly 16.

Only the bench scenarios can show the following:
- The counter steps at the right rate.
- Counter writes are dropped.
- The snapshot stays the same over time.
- Write-one-to-clear spares the bits written as zero.
- A compare value that has already passed never matches.
- A second match during a pulse is absorbed.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  localparam int unsigned DW = 32;

  // Register byte offsets
  localparam int unsigned OFS_COUNT = 'h00;
  localparam int unsigned OFS_CMP0  = 'h08;  // channel n at OFS_CMP0 + 4*n
  localparam int unsigned OFS_IEN   = 'h24;
  localparam int unsigned OFS_WDEN  = 'h28;
  localparam int unsigned OFS_STAT  = 'h2C;
  localparam int unsigned OFS_TRIG  = 'h30;
  localparam int unsigned OFS_SNAP  = 'h34;
endpackage

// File: rtl/tcw_prescaler.sv
module tcw_prescaler #(
  parameter int unsigned DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
      tick    <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
      tick    <= 1'b0;
    end
  end

  generate
    if (DIV > 1) begin : g_tick_chk
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R1
    end
  endgenerate
endmodule

// File: rtl/tcw_count_snap.sv
module tcw_count_snap #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          snap_req,
  output logic [CW-1:0] cnt,
  output logic          cnt_step,
  output logic [CW-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cnt_step <= 1'b0;
      snap     <= '0;
    end else begin
      cnt_step <= tick;
      if (tick) cnt <= cnt + 1'b1;
      if (snap_req) snap <= cnt;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));  // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + 1'b1));  // R1
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(snap));  // R4
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> (snap == $past(cnt)));  // R4
endmodule

// File: rtl/tcw_cmp_bank.sv
module tcw_cmp_bank #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        cnt,
  input  logic                 cnt_step,
  input  logic [NUM_CH-1:0]    cmp_we,
  input  logic [CW-1:0]        wdata,
  input  logic [NUM_CH-1:0]    stat_clr,
  output logic [NUM_CH*CW-1:0] cmp_flat,
  output logic [NUM_CH-1:0]    match,
  output logic [NUM_CH-1:0]    status
);
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [CW-1:0] cmp_q;
      logic          st_q;

      // Compares only on the cycle after a step, so a held counter fires once
      assign match[g] = cnt_step && (cnt == cmp_q);

      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_q <= '1;
          st_q  <= 1'b0;
        end else begin
          if (cmp_we[g]) cmp_q <= wdata;
          if (match[g]) st_q <= 1'b1;        // set wins over clear
          else if (stat_clr[g]) st_q <= 1'b0;
        end
      end

      assign cmp_flat[g*CW +: CW] = cmp_q;
      assign status[g]            = st_q;

      AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        match[g] |=> status[g]);  // R5
    end
  endgenerate
endmodule

// File: rtl/tcw_rst_pulse.sv
module tcw_rst_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic rst_o
);
  localparam int unsigned LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else if (left_q != '0) left_q <= left_q - 1'b1;  // fire ignored while busy
    else if (fire) left_q <= LW'(LEN);
  end

  assign rst_o = (left_q != '0);

  // Independent pulse-length monitor
  logic [LW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (rst_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> $past(fire));  // R8
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    rst_o |-> (run_q < (LW+1)'(LEN)));  // R9
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> (run_q == (LW+1)'(LEN)));  // R9
endmodule

// File: rtl/tcw_timer_wdog.sv
module tcw_timer_wdog
  import tcw_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned TICK_HZ = 1_000_000,
  parameter int unsigned NUM_CH  = 6,   // offsets stop below 0x24, so at most 7
  parameter int unsigned WDOG_CH = 5,
  parameter int unsigned RST_LEN = 16,
  parameter int unsigned AW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq_o,
  output logic          wdog_rst_o
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  logic                 tick;
  logic [DW-1:0]        cnt;
  logic                 cnt_step;
  logic [DW-1:0]        snap;
  logic                 snap_req;
  logic [NUM_CH-1:0]    cmp_we;
  logic [NUM_CH-1:0]    stat_clr;
  logic [NUM_CH*DW-1:0] cmp_flat;
  logic [NUM_CH-1:0]    match;
  logic [NUM_CH-1:0]    status;
  logic [NUM_CH-1:0]    ie_q;
  logic                 wden_q;
  logic                 fire;
  logic [DW-1:0]        rd_mux;

  tcw_prescaler #(.DIV(DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  tcw_count_snap #(.CW(DW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .snap_req(snap_req),
    .cnt     (cnt),
    .cnt_step(cnt_step),
    .snap    (snap)
  );

  tcw_cmp_bank #(.NUM_CH(NUM_CH), .CW(DW)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cnt_step(cnt_step),
    .cmp_we  (cmp_we),
    .wdata   (bus_wdata),
    .stat_clr(stat_clr),
    .cmp_flat(cmp_flat),
    .match   (match),
    .status  (status)
  );

  tcw_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .rst_o(wdog_rst_o)
  );

  // Write decode
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cmp_we[i] = bus_wr && (bus_addr == AW'(OFS_CMP0 + 4*i));
    end
    stat_clr = (bus_wr && bus_addr == AW'(OFS_STAT)) ? bus_wdata[NUM_CH-1:0] : '0;
    snap_req = bus_wr && (bus_addr == AW'(OFS_TRIG)) && bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      wden_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(OFS_IEN))  ie_q   <= bus_wdata[NUM_CH-1:0];
      if (bus_addr == AW'(OFS_WDEN)) wden_q <= bus_wdata[0];
    end
  end

  // Watchdog gating: both enables must be set
  assign fire = match[WDOG_CH] && wden_q && ie_q[WDOG_CH];

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status & ie_q);
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_COUNT)) rd_mux = cnt;
    if (bus_addr == AW'(OFS_IEN))   rd_mux = DW'(ie_q);
    if (bus_addr == AW'(OFS_WDEN))  rd_mux = DW'(wden_q);
    if (bus_addr == AW'(OFS_STAT))  rd_mux = DW'(status);
    if (bus_addr == AW'(OFS_SNAP))  rd_mux = snap;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == AW'(OFS_CMP0 + 4*i)) rd_mux = cmp_flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_WD_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst_o) |-> ($past(wden_q) && $past(ie_q[WDOG_CH])));  // R8
  AST_WD_OFF: assert property (@(posedge clk) disable iff (rst)
    !wden_q |=> !$rose(wdog_rst_o));  // R10
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    (|(status & ie_q)) |=> irq_o);  // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);  // R11
endmodule

// File: tb/tcw_timer_wdog_tb.sv
`timescale 1ns/1ps
module tcw_timer_wdog_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_o;
  logic        wdog_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int rises = 0;
  int highs = 0;
  logic prev_rst = 1'b0;

  // Scoreboard queues: expected value, requirement, check-or-capture
  logic [31:0] exp_q[$];
  int          req_q[$];
  bit          chk_q[$];
  logic [31:0] cap_q[$];

  always #2.5 clk = ~clk;

  tcw_timer_wdog #(.CLK_HZ(4), .TICK_HZ(1)) dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
  );

  // Monitor: pops expectations as read data appears
  always @(negedge clk) begin
    if (!rst) begin
      if (wdog_rst_o && !prev_rst) rises++;
      if (wdog_rst_o) highs++;
      prev_rst <= wdog_rst_o;
      if (bus_rvalid) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R11 unexpected read data actual=%h expected=none", bus_rdata);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic int r = req_q.pop_front();
          automatic bit c = chk_q.pop_front();
          if (c) begin
            n_chk++;
            if (bus_rdata !== e) begin
              n_fail++;
              $display("FAIL R%0d read actual=%h expected=%h", r, bus_rdata, e);
            end
          end else cap_q.push_back(bus_rdata);
        end
      end
    end
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input int req, input bit c);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); req_q.push_back(req); chk_q.push_back(c);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_get(input logic [7:0] a, output logic [31:0] v);
    rd(a, '0, 0, 1'b0);
    @(posedge clk); #1;
    v = cap_q.pop_front();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] v, v2, s1, s2;
    int r0, h0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R2 reset state
    check(2, {31'd0, irq_o}, 32'd0);
    check(2, {31'd0, wdog_rst_o}, 32'd0);
    rd_get(8'h00, v);
    check(2, {31'd0, (v < 32'd3)}, 32'd1);
    for (int i = 0; i < 6; i++) rd(8'(8 + 4*i), 32'hFFFF_FFFF, 2, 1'b1);
    rd(8'h24, 32'd0, 2, 1'b1);
    rd(8'h28, 32'd0, 2, 1'b1);
    rd(8'h2C, 32'd0, 2, 1'b1);
    rd(8'h34, 32'd0, 2, 1'b1);

    // R1 step rate: reads 32 clocks apart differ by 32/DIV
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h00;
    exp_q.push_back('0); req_q.push_back(1); chk_q.push_back(1'b0);
    @(negedge clk); bus_rd = 1'b0;
    repeat (31) @(negedge clk);
    bus_rd = 1'b1;
    exp_q.push_back('0); req_q.push_back(1); chk_q.push_back(1'b0);
    @(negedge clk); bus_rd = 1'b0;
    @(posedge clk); #1;
    v = cap_q.pop_front(); v2 = cap_q.pop_front();
    check(1, v2 - v, 32'(32 / DIV));
    // R1 counter write is dropped
    wr(8'h00, 32'hDEAD_0000);
    rd_get(8'h00, v);
    check(1, {31'd0, (v < 32'h1000)}, 32'd1);

    // R3 compare read/write
    for (int i = 0; i < 6; i++) wr(8'(8 + 4*i), 32'h1000_0000 + 32'(i * 'h111));
    for (int i = 0; i < 6; i++) rd(8'(8 + 4*i), 32'h1000_0000 + 32'(i * 'h111), 3, 1'b1);

    // R4 latch
    wr(8'h30, 32'h0000_0002);
    rd(8'h34, 32'd0, 4, 1'b1);
    wr(8'h30, 32'd1);
    rd_get(8'h34, s1);
    rd_get(8'h00, v);
    check(4, {31'd0, (v >= s1) && (v - s1 < 32'd4) && (s1 != 0)}, 32'd1);
    idle(40);
    rd(8'h34, s1, 4, 1'b1);
    wr(8'h30, 32'd1);
    rd_get(8'h34, s2);
    check(4, {31'd0, (s2 > s1)}, 32'd1);

    // R5 match, exact only; R7 masked
    rd_get(8'h00, v);
    wr(8'h08, v + 32'd5);
    wr(8'h0C, v - 32'd1);
    idle(40);
    rd(8'h2C, 32'h01, 5, 1'b1);
    check(7, {31'd0, irq_o}, 32'd0);
    // R6 write-0 leaves bits
    wr(8'h2C, 32'h3E);
    rd(8'h2C, 32'h01, 6, 1'b1);
    // R7 enable unmasks
    wr(8'h24, 32'h01);
    idle(1);
    check(7, {31'd0, irq_o}, 32'd1);
    idle(40);
    rd(8'h2C, 32'h01, 5, 1'b1);  // R5 sticky
    wr(8'h2C, 32'h01);
    idle(3);
    rd(8'h2C, 32'h00, 6, 1'b1);
    check(7, {31'd0, irq_o}, 32'd0);

    // R8 no reset with enable bit 5 clear
    r0 = rises;
    wr(8'h24, 32'h01);
    wr(8'h28, 32'd1);
    rd_get(8'h00, v);
    wr(8'h1C, v + 32'd5);
    idle(40);
    check(8, 32'(rises - r0), 32'd0);
    rd(8'h2C, 32'h20, 8, 1'b1);
    wr(8'h2C, 32'h3F);

    // R10 watchdog enable off blocks reset
    wr(8'h24, 32'h20);
    wr(8'h28, 32'd0);
    rd_get(8'h00, v);
    wr(8'h1C, v + 32'd5);
    idle(40);
    check(10, 32'(rises - r0), 32'd0);
    wr(8'h2C, 32'h3F);

    // R8/R9 armed: one 16-cycle pulse
    r0 = rises; h0 = highs;
    wr(8'h28, 32'd1);
    rd(8'h28, 32'd1, 8, 1'b1);
    rd_get(8'h00, v);
    wr(8'h1C, v + 32'd5);
    idle(60);
    check(8, 32'(rises - r0), 32'd1);
    check(9, 32'(highs - h0), 32'd16);
    check(7, {31'd0, irq_o}, 32'd1);
    wr(8'h2C, 32'h3F);

    // R9 match during pulse is absorbed
    r0 = rises; h0 = highs;
    rd_get(8'h00, v);
    wr(8'h1C, v + 32'd4);
    for (int k = 0; k < 40 && !wdog_rst_o; k++) idle(1);
    rd_get(8'h00, v);
    wr(8'h1C, v + 32'd2);
    idle(80);
    check(9, 32'(rises - r0), 32'd1);
    check(9, 32'(highs - h0), 32'd16);
    rd(8'h2C, 32'h20, 5, 1'b1);

    // R11 unmapped reads zero; all reads answered
    rd(8'h3C, 32'd0, 11, 1'b1);
    rd(8'h20, 32'd0, 11, 1'b1);
    idle(4);
    check(11, 32'(exp_q.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule